// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a small register-mapped watchdog. An up-counter advances once per prescaled tick of the peripheral clock. A three-bit clock-select code picks a power-of-two divider, and the counter is enabled by a bit in the control/status register. When the counter rolls over from all ones to zero, a sticky overflow flag is set. In watchdog mode the rollover also raises a one-clock reset request. A reset-kind output tells the reset controller which kind of reset is wanted. Software keeps the system alive by writing zero to the counter before it rolls over.

Bring-up follows a fixed order. First write the mode bit and clock select while the timer is stopped. Then zero the counter. Then set the enable bit and choose the reset kind in the same write. While the timer is enabled, the mode bit and the clock-select field are locked. Either the counter write or the enable edge restarts the prescaler, so the first tick always comes one full divider period after that write.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x00, the counter (address 1) reads 0x00, and `rst_req_o` and `ovf_flag_o` are low.
- R2: The counter advances only while the enable bit (bit 0 of the control/status register) is set. Clearing that bit freezes the counter at its value.
- R3: The rollover from 0xFF to 0x00 sets the overflow flag (bit 3 of the control/status register, also driven on `ovf_flag_o`). The counter keeps counting from 0x00 afterwards.
- R4: If the mode bit (bit 1) is 1 (watchdog mode), a rollover drives `rst_req_o` high for exactly one clock, and `rst_kind_o` shows the reset-select bit (bit 2). If the mode bit is 0 (interval mode), a rollover sets only the flag.
- R5: Software cannot set the overflow flag. Writing a 1 to bit 3 leaves the flag unchanged, and writing a 0 clears it. If a clearing write and a rollover fall in the same clock, the flag stays set.
- R6: A write to address 1 loads the counter with the write data and restarts the prescaler. When the write and a tick fall in the same clock, the write wins.
- R7: A write that sets the enable bit while it is clear restarts the prescaler. The first count after enabling comes 2^(code+BASE_SHIFT) clocks after that write.
- R8: The mode bit and the clock-select field (bits 6:4) take a written value only while the enable bit is currently clear. Writes made while the timer is enabled leave both unchanged.
- R9: Clock-select code c divides the clock by 2^(c+BASE_SHIFT). The full overflow period is 256 times that divider. With the default BASE_SHIFT of 5, codes 5, 6 and 7 divide by 1024, 2048 and 4096.
- R10: Addresses 2 and 3 read as 0x00, and writes to them change nothing. Bit 7 of the control/status register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address: 0 is control/status, 1 is counter |
| wr_en_i | input | 1 | Write strobe for the current clock |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| rst_req_o | output | 1 | One-clock reset request on a watchdog-mode overflow |
| rst_kind_o | output | 1 | Reset kind chosen by the reset-select bit |

## Verification
The embedded properties check the following on every clock:
- the counter is loaded on a write and frozen when there is no tick;
- the prescaler is cleared on a restart;
- the flag stays set and is forced on a rollover;
- the mode and clock-select fields are locked while enabled;
- the reset request lasts exactly one clock and comes only with watchdog mode and a set flag.

Only the directed scenarios can show the exact clock of each count and rollover for a given select code. They also show:
- the silence of interval mode;
- the protection of unmapped addresses;
- a clearing write that collides with a rollover.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W   = 8;
    localparam int CKS_W    = 3;
    localparam int NUM_CKS  = 1 << CKS_W;

    localparam int BIT_EN   = 0;
    localparam int BIT_MODE = 1;
    localparam int BIT_RSEL = 2;
    localparam int BIT_OVF  = 3;
    localparam int CKS_LSB  = 4;

    localparam int ADDR_CSR = 0;
    localparam int ADDR_CNT = 1;

    typedef struct packed {
        logic             en;
        logic             mode;
        logic             rsel;
        logic             ovf;
        logic [CKS_W-1:0] cks;
    } csr_t;

    function automatic logic [DATA_W-1:0] csr_pack(input csr_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_EN]                = c.en;
        v[BIT_MODE]              = c.mode;
        v[BIT_RSEL]              = c.rsel;
        v[BIT_OVF]               = c.ovf;
        v[CKS_LSB +: CKS_W]      = c.cks;
        return v;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int BASE_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [CKS_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int PRE_W = (NUM_CKS - 1) + BASE_SHIFT;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic [PRE_W-1:0] mask_tbl [NUM_CKS];
    logic [PRE_W-1:0] mask_sel;

    for (genvar g = 0; g < NUM_CKS; g++) begin : g_mask
        localparam logic [PRE_W:0] ONE_SH = (PRE_W+1)'(1) << (g + BASE_SHIFT);
        assign mask_tbl[g] = ONE_SH[PRE_W-1:0] - 1'b1;
    end

    assign mask_sel = mask_tbl[sel_i];
    assign tick_o   = run_i && !clr_i && ((state_q.pre & mask_sel) == mask_sel);

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.pre = '0;
        end else if (run_i) begin
            state_d.pre = state_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: a restart leaves the divider at zero
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q.pre == '0));

    // R2: a stopped divider does not move
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(state_q.pre));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    assign wrap_o = tick_i && !load_i && (state_q.cnt == CNT_MAX);
    assign cnt_o  = state_q.cnt;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.cnt = load_val_i;
        end else if (tick_i) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R6: a write lands in the counter on the next clock
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q.cnt == $past(load_val_i)));

    // R2: no tick and no write means no change
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(state_q.cnt));

    // R3: a rollover leaves the counter at zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (state_q.cnt == '0));

endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  csr_t wr_fields_i,
    input  logic wrap_i,
    output csr_t csr_o,
    output logic start_o,
    output logic rst_req_o
);

    typedef struct packed {
        csr_t csr;
        logic rst_req;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        if (wr_i) begin
            state_d.csr.en   = wr_fields_i.en;
            state_d.csr.rsel = wr_fields_i.rsel;
            state_d.csr.ovf  = state_q.csr.ovf & wr_fields_i.ovf;
            if (!state_q.csr.en) begin
                state_d.csr.mode = wr_fields_i.mode;
                state_d.csr.cks  = wr_fields_i.cks;
            end
            start_o = wr_fields_i.en && !state_q.csr.en;
        end
        if (wrap_i) begin
            state_d.csr.ovf = 1'b1;
        end
        state_d.rst_req = wrap_i && state_q.csr.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign csr_o     = state_q.csr;
    assign rst_req_o = state_q.rst_req;

    // R5: flag survives anything but a clearing write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.csr.ovf && !(wr_i && !wr_fields_i.ovf)) |=> state_q.csr.ovf);

    // R5: a rollover always leaves the flag set
    a_r5_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> state_q.csr.ovf);

    // R5: without a rollover the flag cannot rise
    a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.csr.ovf && !wrap_i) |=> !state_q.csr.ovf);

    // R8: mode and clock select are frozen while running
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.csr.en |=> ($stable(state_q.csr.mode) && $stable(state_q.csr.cks)));

    // R4: request is a single clock wide
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rst_req |=> !state_q.rst_req);

    // R4: request only in watchdog mode, alongside the flag
    a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rst_req |-> (state_q.csr.mode && state_q.csr.ovf));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_SHIFT = 5,
    parameter int CNT_W      = 8,
    parameter int ADDR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ovf_flag_o,
    output logic              rst_req_o,
    output logic              rst_kind_o
);

    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(ADDR_CSR);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_CNT);

    logic             sel_csr, sel_cnt;
    logic             wr_csr, wr_cnt;
    csr_t             wr_fields;
    csr_t             csr;
    logic             start;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    assign sel_csr = (addr_i == A_CSR);
    assign sel_cnt = (addr_i == A_CNT);
    assign wr_csr  = wr_en_i && sel_csr;
    assign wr_cnt  = wr_en_i && sel_cnt;

    always_comb begin
        wr_fields      = '0;
        wr_fields.en   = wdata_i[BIT_EN];
        wr_fields.mode = wdata_i[BIT_MODE];
        wr_fields.rsel = wdata_i[BIT_RSEL];
        wr_fields.ovf  = wdata_i[BIT_OVF];
        wr_fields.cks  = wdata_i[CKS_LSB +: CKS_W];
    end

    wdog_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_csr),
        .wr_fields_i(wr_fields),
        .wrap_i     (wrap),
        .csr_o      (csr),
        .start_o    (start),
        .rst_req_o  (rst_req_o)
    );

    wdog_prescaler #(.BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (csr.en),
        .clr_i (wr_cnt || start),
        .sel_i (csr.cks),
        .tick_o(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .load_i    (wr_cnt),
        .load_val_i(wdata_i[CNT_W-1:0]),
        .cnt_o     (cnt),
        .wrap_o    (wrap)
    );

    always_comb begin
        rdata_o = '0;
        if (sel_csr) begin
            rdata_o = csr_pack(csr);
        end else if (sel_cnt) begin
            rdata_o = DATA_W'(cnt);
        end
    end

    assign ovf_flag_o = csr.ovf;
    assign rst_kind_o = csr.rsel;

    // R2: a disabled timer never requests a count
    a_r2_no_tick_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !csr.en |-> !tick);

    // R4: reset kind is steady across the request pulse
    a_r4_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> (rst_kind_o == csr.rsel));

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       ovf_flag, rst_req, rst_kind;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdog_timer #(.BASE_SHIFT(0), .CNT_W(8), .ADDR_W(2)) u_wdog_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .ovf_flag_o(ovf_flag),
        .rst_req_o (rst_req),
        .rst_kind_o(rst_kind)
    );

    function automatic logic [7:0] cv(input bit en, input bit mode, input bit rsel,
                                      input bit ovf, input logic [2:0] cks);
        return {1'b0, cks, ovf, rsel, mode, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller stands at a falling edge; write lands on the next rising edge
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); chk("R1 csr", v, 8'h00);
        rd(2'd1, v); chk("R1 cnt", v, 8'h00);
        chk("R1 rst_req", rst_req, 1'b0);
        chk("R1 ovf", ovf_flag, 1'b0);
    endtask

    task automatic t_divide;
        logic [7:0] v;
        bus_wr(2'd0, cv(0, 1, 0, 0, 3'd3));
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, cv(1, 1, 0, 0, 3'd3));
        repeat (7) @(negedge clk);
        rd(2'd1, v); chk("R7 no count before 8 clocks", v, 8'h00);
        @(negedge clk);
        rd(2'd1, v); chk("R9 first count at 8 clocks", v, 8'h01);
        repeat (8) @(negedge clk);
        rd(2'd1, v); chk("R2 second count", v, 8'h02);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        bus_wr(2'd0, cv(1, 0, 0, 0, 3'd6));
        rd(2'd0, v); chk("R8 mode and cks locked", v, cv(1, 1, 0, 0, 3'd3));
    endtask

    task automatic t_freeze;
        logic [7:0] v0, v1;
        bus_wr(2'd0, cv(0, 1, 0, 0, 3'd3));
        rd(2'd1, v0);
        repeat (50) @(negedge clk);
        rd(2'd1, v1); chk("R2 frozen when disabled", v1, v0);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        bus_wr(2'd0, cv(0, 1, 1, 0, 3'd0));
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, cv(1, 1, 1, 0, 3'd0));
        repeat (255) @(negedge clk);
        rd(2'd1, v); chk("R3 cnt before wrap", v, 8'hFF);
        chk("R3 flag before wrap", ovf_flag, 1'b0);
        chk("R4 no request before wrap", rst_req, 1'b0);
        @(negedge clk);
        rd(2'd1, v); chk("R3 cnt after wrap", v, 8'h00);
        chk("R3 flag set", ovf_flag, 1'b1);
        chk("R4 request", rst_req, 1'b1);
        chk("R4 kind", rst_kind, 1'b1);
        @(negedge clk);
        chk("R4 one clock", rst_req, 1'b0);
        rd(2'd1, v); chk("R3 keeps counting", v, 8'h01);
    endtask

    task automatic t_sticky;
        logic [7:0] v;
        bus_wr(2'd0, cv(1, 1, 1, 1, 3'd0));
        rd(2'd0, v); chk("R5 write one keeps flag", v, cv(1, 1, 1, 1, 3'd0));
        bus_wr(2'd0, cv(1, 1, 1, 0, 3'd0));
        rd(2'd0, v); chk("R5 write zero clears", v, cv(1, 1, 1, 0, 3'd0));
        bus_wr(2'd0, cv(1, 1, 1, 1, 3'd0));
        chk("R5 software cannot set", ovf_flag, 1'b0);
        bus_wr(2'd1, 8'hFF);
        bus_wr(2'd0, cv(1, 1, 1, 0, 3'd0));
        chk("R5 rollover beats clear", ovf_flag, 1'b1);
        chk("R4 request on collision", rst_req, 1'b1);
    endtask

    task automatic t_load;
        logic [7:0] v;
        bus_wr(2'd1, 8'h80);
        rd(2'd1, v); chk("R6 load value", v, 8'h80);
        @(negedge clk);
        rd(2'd1, v); chk("R6 counts on from load", v, 8'h81);
    endtask

    task automatic t_interval;
        logic [7:0] v;
        int bad = 0;
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'hF0);
        bus_wr(2'd0, cv(1, 0, 0, 0, 3'd0));
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_req !== 1'b0) bad++;
        end
        chk("R4 interval mode no request", bad, 0);
        chk("R3 interval flag", ovf_flag, 1'b1);
        rd(2'd1, v); chk("R3 interval count", v, 8'h04);
    endtask

    task automatic t_unmapped;
        logic [7:0] v, c0;
        bus_wr(2'd0, 8'h00);
        rd(2'd1, c0);
        bus_wr(2'd2, 8'hFF);
        bus_wr(2'd3, 8'hFF);
        rd(2'd0, v); chk("R10 csr untouched", v, 8'h00);
        rd(2'd1, v); chk("R10 cnt untouched", v, c0);
        @(negedge clk);
        rd(2'd2, v); chk("R10 addr 2 reads zero", v, 8'h00);
        rd(2'd3, v); chk("R10 addr 3 reads zero", v, 8'h00);
        bus_wr(2'd0, 8'hF0);
        rd(2'd0, v); chk("R10 bit 7 reads zero", v, 8'h70);
    endtask

    task automatic t_code5;
        logic [7:0] v;
        bus_wr(2'd0, cv(0, 0, 0, 0, 3'd5));
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, cv(1, 0, 0, 0, 3'd5));
        repeat (8191) @(negedge clk);
        chk("R9 code 5 no flag yet", ovf_flag, 1'b0);
        @(negedge clk);
        chk("R9 code 5 period 8192", ovf_flag, 1'b1);
        rd(2'd1, v); chk("R9 code 5 wrapped", v, 8'h00);
    endtask

    task automatic t_code7;
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, cv(0, 0, 0, 0, 3'd7));
        bus_wr(2'd1, 8'hFE);
        bus_wr(2'd0, cv(1, 0, 0, 0, 3'd7));
        repeat (255) @(negedge clk);
        chk("R9 code 7 no flag yet", ovf_flag, 1'b0);
        @(negedge clk);
        chk("R9 code 7 two ticks of 128", ovf_flag, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = 2'd0;
        wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_lock();
        t_freeze();
        t_overflow();
        t_sticky();
        t_load();
        t_interval();
        t_unmapped();
        t_code5();
        t_code7();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule